// File: doc/BRIEF.md
# Masked Error Interrupt Hub

This block gathers the error events of a multi-channel audio converter front end and drives one active-low interrupt line from them. It has four sources. Each ADC has its own overflow strobe. There is a clocking error strobe and a test-mode-entry strobe. The fourth source is produced inside the block: it watches the serial port configuration fields and flags a serial port error whenever one of them changes while any converter is still running. Every event sets a sticky status bit. A host-writable 8-bit mask decides which of those bits may pull the interrupt line low.

The host reaches the block through a plain register port with two registers, selected by `reg_sel`. Select 0 is the mask and select 1 is the status. Reading the status returns its contents and clears it. Writing the status clears each bit written as 1. The mask works in the inverted sense: a 1 stops its source from asserting the interrupt, and it never stops the status bit from being set.

Top module: `err_irq_hub`

## Requirements
- R1: The mask and status registers share one bit layout. Bit 7 is the test mode error, bit 6 the serial port error and bit 5 the clocking error. Bit 4 is reserved. Bits 3, 2, 1 and 0 are the overflow events of ADC4, ADC3, ADC2 and ADC1.
- R2: A one-cycle strobe on any source sets its status bit at the next clock edge. The bit then stays set until the host clears it, whatever the mask holds.
- R3: `irq_n` goes low one cycle after a status bit is set whose mask bit is 0. It stays high when every set status bit has its mask bit at 1.
- R4: A change of `cfg_fmt`, `cfg_speed` or `cfg_master` while at least one `pd_adc` or `pd_dac` bit is 0 sets the serial port error bit. Each change produces exactly one event.
- R5: A configuration change made while every ADC and every DAC power-down bit is 1 raises no serial port error.
- R6: A `ratio_chg` strobe with `cfg_master` = 0 (slave mode) while not fully powered down sets both the serial port error bit and the clocking error bit. The same strobe has no effect in master mode (`cfg_master` = 1) or when fully powered down.
- R7: Reading the status (`reg_sel` = 1) clears every bit that the read returns. Writing the status clears the bits written as 1. An event that arrives in the same cycle as a clear leaves its bit set.
- R8: Mask bit 4 and status bit 4 always read 0, and writes to bit 4 are ignored.
- R9: After reset the status is 0, `irq_n` is 1 and the mask reads 8'hEF, so every implemented source starts masked.
- R10: `rdata_vld` is high for one cycle, one cycle after `reg_rd`. In that cycle `reg_rdata` holds the register selected when `reg_rd` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | FMT_W | Serial format field |
| cfg_speed | input | SPD_W | Speed mode field |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| pd_adc | input | N_ADC | Per-ADC power-down bits |
| pd_dac | input | N_DAC | Per-DAC power-down bits |
| adc_ovf | input | N_ADC | Per-ADC overflow strobes |
| clk_err | input | 1 | Clocking error strobe |
| ratio_chg | input | 1 | Master-clock-to-sample-rate ratio changed |
| test_entry | input | 1 | Test mode entered by a register write |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | 0 = mask, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| rdata_vld | output | 1 | Read data valid |
| status | output | 8 | Sticky status bits |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a clear that meets a new event in the same cycle. The bench reaches it by raising a status read and a second overflow strobe on the same edge. The read must return the old bits, and afterwards only the new bit may remain. The serial port error is the other hard case, because it depends on the value of the configuration fields one cycle earlier. The bench moves each field once with one DAC still running. It clears the error and then waits several idle cycles to prove that no second pulse follows. It repeats the same moves with everything powered down, and in master mode, where the status has to stay at zero.

// File: rtl/ehub_pkg.sv
package ehub_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_TST = 7;
  localparam int BIT_SP  = 6;
  localparam int BIT_CLK = 5;
  localparam int BIT_RSV = 4;
  localparam int ADC_MAX = 4;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  function automatic logic [REG_W-1:0] impl_bits(input int n_adc);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_TST] = 1'b1;
    v[BIT_SP]  = 1'b1;
    v[BIT_CLK] = 1'b1;
    for (int i = 0; i < ADC_MAX; i++) begin
      if (i < n_adc) v[i] = 1'b1;
    end
    return v;
  endfunction
endpackage

// File: rtl/ehub_cfg_watch.sv
module ehub_cfg_watch #(
  parameter int FMT_W = 2,
  parameter int SPD_W = 2,
  parameter int N_ADC = 4,
  parameter int N_DAC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FMT_W-1:0] fmt,
  input  logic [SPD_W-1:0] speed,
  input  logic             master,
  input  logic [N_ADC-1:0] pd_adc,
  input  logic [N_DAC-1:0] pd_dac,
  input  logic             ratio_stb,
  output logic             sp_err,
  output logic             ratio_err
);
  localparam int CW = FMT_W + SPD_W + 1;

  logic [CW-1:0] cur_cfg;
  logic [CW-1:0] prev_cfg;
  logic          primed;
  logic          all_off;
  logic          cfg_moved;

  assign cur_cfg = {fmt, speed, master};
  assign all_off = (&pd_adc) && (&pd_dac);

  // Copy follows the fields every cycle, so one change gives one pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cfg <= '0;
      primed   <= 1'b0;
    end else begin
      prev_cfg <= cur_cfg;
      primed   <= 1'b1;
    end
  end

  assign cfg_moved = primed && (cur_cfg != prev_cfg);
  assign ratio_err = ratio_stb && !master && !all_off;
  assign sp_err    = (cfg_moved && !all_off) || ratio_err;

  // R4: a pulse repeats only if the fields move again or the ratio strobes
  p_one_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (sp_err && !ratio_stb) |=> (!sp_err || !$stable(cur_cfg) || ratio_stb));

  // R6: master mode never turns a ratio strobe into an error
  p_master_ratio_r6: assert property (@(posedge clk) disable iff (rst)
    master |-> !ratio_err);
endmodule

// File: rtl/ehub_status.sv
module ehub_status #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  // Set wins over clear; unimplemented bits stay at zero.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (set | (q & ~clr)) & IMPL;
  end

  // R2: an implemented set always lands in the status
  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    ((set & IMPL) != '0) |=> ((q & $past(set & IMPL)) == $past(set & IMPL)));

  // R2: a set bit that is not cleared stays set
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    ((q & ~clr) != '0) |=> ((q & $past(q & ~clr)) == $past(q & ~clr)));
endmodule

// File: rtl/ehub_regs.sv
module ehub_regs
  import ehub_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = 8'hEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] stat,
  output logic [REG_W-1:0] clr,
  output logic [REG_W-1:0] rdata,
  output logic             rdata_vld,
  output logic             irq_n
);
  logic [REG_W-1:0] mask_q;
  logic             sel_stat;

  assign sel_stat = (sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (rst) mask_q <= IMPL;
    else if (wr && !sel_stat) mask_q <= wdata & IMPL;
  end

  always_comb begin
    clr = '0;
    if (rd && sel_stat)      clr = stat;
    else if (wr && sel_stat) clr = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
      irq_n     <= 1'b1;
    end else begin
      rdata     <= sel_stat ? stat : mask_q;
      rdata_vld <= rd;
      irq_n     <= ~|(stat & ~mask_q & IMPL);
    end
  end

  // R3: an unmasked pending bit pulls the line low one cycle later
  p_irq_low_r3: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~mask_q) != '0) |=> !irq_n);

  // R3: with nothing unmasked pending the line is high one cycle later
  p_irq_high_r3: assert property (@(posedge clk) disable iff (rst)
    ((stat & ~mask_q) == '0) |=> irq_n);

  // R8: the reserved mask bit never holds a 1
  p_mask_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
    !mask_q[BIT_RSV]);

  // R10: data valid follows a read by one cycle
  p_rd_vld_r10: assert property (@(posedge clk) disable iff (rst)
    rd |=> rdata_vld);
endmodule

// File: rtl/err_irq_hub.sv
module err_irq_hub
  import ehub_pkg::*;
#(
  parameter int FMT_W = 2,
  parameter int SPD_W = 2,
  parameter int N_ADC = 4,
  parameter int N_DAC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FMT_W-1:0] cfg_fmt,
  input  logic [SPD_W-1:0] cfg_speed,
  input  logic             cfg_master,
  input  logic [N_ADC-1:0] pd_adc,
  input  logic [N_DAC-1:0] pd_dac,
  input  logic [N_ADC-1:0] adc_ovf,
  input  logic             clk_err,
  input  logic             ratio_chg,
  input  logic             test_entry,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             rdata_vld,
  output logic [7:0]       status,
  output logic             irq_n
);
  localparam logic [REG_W-1:0] IMPL = impl_bits(N_ADC);

  logic             sp_err;
  logic             ratio_err;
  logic [REG_W-1:0] set_v;
  logic [REG_W-1:0] clr_v;

  ehub_cfg_watch #(
    .FMT_W(FMT_W), .SPD_W(SPD_W), .N_ADC(N_ADC), .N_DAC(N_DAC)
  ) u_watch (
    .clk      (clk),
    .rst      (rst),
    .fmt      (cfg_fmt),
    .speed    (cfg_speed),
    .master   (cfg_master),
    .pd_adc   (pd_adc),
    .pd_dac   (pd_dac),
    .ratio_stb(ratio_chg),
    .sp_err   (sp_err),
    .ratio_err(ratio_err)
  );

  generate
    for (genvar i = 0; i < ADC_MAX; i++) begin : g_adc
      if (i < N_ADC) begin : g_on
        assign set_v[i] = adc_ovf[i];
      end else begin : g_off
        assign set_v[i] = 1'b0;
      end
    end
  endgenerate

  assign set_v[BIT_RSV] = 1'b0;
  assign set_v[BIT_CLK] = clk_err | ratio_err;
  assign set_v[BIT_SP]  = sp_err;
  assign set_v[BIT_TST] = test_entry;

  ehub_status #(.W(REG_W), .IMPL(IMPL)) u_stat (
    .clk(clk),
    .rst(rst),
    .set(set_v),
    .clr(clr_v),
    .q  (status)
  );

  ehub_regs #(.IMPL(IMPL)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .sel      (reg_sel),
    .wdata    (reg_wdata),
    .stat     (status),
    .clr      (clr_v),
    .rdata    (reg_rdata),
    .rdata_vld(rdata_vld),
    .irq_n    (irq_n)
  );

  // R8: the reserved status bit stays clear
  p_stat_rsvd_r8: assert property (@(posedge clk) disable iff (rst)
    !status[BIT_RSV]);

  // R6: a slave-mode ratio change while running raises both errors together
  p_ratio_both_r6: assert property (@(posedge clk) disable iff (rst)
    (ratio_chg && !cfg_master && !((&pd_adc) && (&pd_dac)))
      |=> (status[BIT_SP] && status[BIT_CLK]));
endmodule

// File: tb/err_irq_hub_bench.sv
module err_irq_hub_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cfg_fmt, cfg_speed;
  logic       cfg_master;
  logic [3:0] pd_adc, pd_dac, adc_ovf;
  logic       clk_err, ratio_chg, test_entry;
  logic       reg_wr, reg_rd, reg_sel;
  logic [7:0] reg_wdata, reg_rdata, status;
  logic       rdata_vld, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  err_irq_hub u_err_irq_hub (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_speed(cfg_speed),
    .cfg_master(cfg_master), .pd_adc(pd_adc), .pd_dac(pd_dac),
    .adc_ovf(adc_ovf), .clk_err(clk_err), .ratio_chg(ratio_chg),
    .test_entry(test_entry), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rdata_vld(rdata_vld), .status(status), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Driver: a read pushes its expected value for the monitor.
  task automatic do_read(input logic sel, input logic [7:0] exp, input string tag);
    reg_rd = 1'b1; reg_sel = sel;
    exp_q.push_back(exp); tag_q.push_back(tag);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse_adc(input int idx);
    adc_ovf[idx] = 1'b1; tick(); adc_ovf = '0;
  endtask

  // Monitor: pops expected read data as it appears.
  always @(negedge clk) begin
    if (!rst && rdata_vld === 1'b1) begin
      if (exp_q.size() == 0) check("R10 unexpected read data", 8'hFF, 8'h00);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_fmt = '0; cfg_speed = '0; cfg_master = 1'b0;
    pd_adc = 4'hF; pd_dac = 4'hF; adc_ovf = '0; clk_err = 0; ratio_chg = 0;
    test_entry = 0; reg_wr = 0; reg_rd = 0; reg_sel = 0; reg_wdata = '0;
    repeat (3) tick();
    rst = 1'b0; tick();
    check("R9 status after reset", status, 8'h00);
    check("R9 irq_n after reset", {7'd0, irq_n}, 8'h01);
    do_read(1'b0, 8'hEF, "R9 mask after reset");

    do_write(1'b0, 8'hFF);
    do_read(1'b0, 8'hEF, "R8 reserved mask bit");
    do_write(1'b0, 8'h00);
    do_read(1'b0, 8'h00, "R10 mask readback");

    pulse_adc(2);
    check("R1 ADC3 overflow bit", status, 8'h04);
    tick();
    check("R3 irq_n low unmasked", {7'd0, irq_n}, 8'h00);
    do_read(1'b1, 8'h04, "R7 status read value");
    check("R7 read clears", status, 8'h00);
    tick();
    check("R3 irq_n released", {7'd0, irq_n}, 8'h01);

    do_write(1'b0, 8'h01);
    pulse_adc(0);
    check("R2 set while masked", status, 8'h01);
    tick();
    check("R3 masked source quiet", {7'd0, irq_n}, 8'h01);
    do_write(1'b1, 8'h01);
    check("R7 write-one clears", status, 8'h00);

    clk_err = 1'b1; tick(); clk_err = 1'b0;
    check("R1 clocking error bit", status, 8'h20);
    test_entry = 1'b1; tick(); test_entry = 1'b0;
    check("R1 test mode bit", status, 8'hA0);
    do_write(1'b1, 8'h20);
    check("R7 partial clear", status, 8'h80);
    do_write(1'b1, 8'hFF);

    pd_dac = 4'h7; tick();
    cfg_fmt = 2'b01; tick();
    check("R4 format change", status, 8'h40);
    do_write(1'b1, 8'hFF);
    repeat (3) tick();
    check("R4 single pulse", status, 8'h00);
    cfg_speed = 2'b10; tick();
    check("R4 speed change", status, 8'h40);
    do_write(1'b1, 8'hFF);
    cfg_master = 1'b1; tick();
    check("R4 master/slave change", status, 8'h40);
    do_write(1'b1, 8'hFF);

    pd_dac = 4'hF; tick();
    cfg_fmt = 2'b10; tick(); tick();
    check("R5 format change powered down", status, 8'h00);
    cfg_speed = 2'b01; tick(); tick();
    check("R5 speed change powered down", status, 8'h00);

    pd_dac = 4'h7; tick();
    ratio_chg = 1'b1; tick(); ratio_chg = 1'b0;
    check("R6 master mode ratio ignored", status, 8'h00);
    pd_dac = 4'hF; tick();
    cfg_master = 1'b0; tick(); tick();
    ratio_chg = 1'b1; tick(); ratio_chg = 1'b0;
    check("R6 powered down ratio ignored", status, 8'h00);
    pd_adc = 4'hE; tick();
    ratio_chg = 1'b1; tick(); ratio_chg = 1'b0;
    check("R6 slave ratio change", status, 8'h60);
    do_write(1'b1, 8'hFF);
    pd_adc = 4'hF; tick();

    pulse_adc(0);
    reg_rd = 1'b1; reg_sel = 1'b1; adc_ovf[1] = 1'b1;
    exp_q.push_back(8'h01); tag_q.push_back("R7 read during event");
    tick();
    reg_rd = 1'b0; adc_ovf = '0;
    check("R7 event wins over clear", status, 8'h02);

    repeat (3) tick();
    check("R10 all reads returned", exp_q.size(), 8'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule